// File: doc/BRIEF.md
# Boot-Overlay Bus Decoder

This block sits on the CPU side of a 16-bit address, 8-bit data bus in a small handheld-console memory map. It steers each access to the cartridge port, the video port, an internal boot image or an internal banked work RAM. It reports on a source-select output which target supplied each read byte. Addresses that belong to no target read as 0xFF and raise no port request.

After reset a boot overlay covers the low cartridge space, but it leaves a hole at 0x0100–0x01FF so that the cartridge header stays readable. Software retires the overlay by writing any value to 0xFF50, and after that only a reset can bring it back. In enhanced mode the overlay reaches further, up to 0x08FF. The upper work-RAM window is served by a bank register at 0xFF70, and a zero written there selects bank 1.

The CPU holds the address stable for the cycle. Read data is combinational in that same cycle. Writes take effect at the rising clock edge.

Top module: `boot_overlay_decoder`

## Requirements
- R1: Coming out of reset, the overlay is enabled when BOOT_PRESENT=1 and disabled when BOOT_PRESENT=0. The work-RAM bank register comes out of reset at 1.
- R2: While the overlay is enabled, a read of 0x0000–0x00FF returns boot byte b(a) = a[7:0] ^ {a[11:8],a[11:8]} ^ BOOT_SEED, with src_o = 3 (boot).
- R3: A read of 0x0100–0x01FF always goes to the cartridge port (src_o = 1), whether or not the overlay is enabled.
- R4: With ENHANCED=1 and the overlay enabled, reads of 0x0200–0x08FF return boot bytes b(a), and 0x0900 reads the cartridge. With ENHANCED=0, reads of 0x0200–0x08FF always go to the cartridge.
- R5: A write of any value to 0xFF50 clears the overlay enable, and no later write sets it again. Writes to 0xFF51–0xFF5F leave the overlay unchanged.
- R6: While the overlay is disabled, reads of 0x0000–0x08FF return cartridge data with src_o = 1.
- R7: Reads and writes in 0xC000–0xCFFF always use work-RAM bank 0, whatever the bank register holds (src_o = 4).
- R8: Reads and writes in 0xD000–0xDFFF use the bank held in the bank register, at offset addr[WRAM_AW-1:0] within that bank.
- R9: A write to 0xFF70 loads the bank register from data bits [2:0] and ignores the upper bits. A loaded value of 0 selects bank 1.
- R10: Reads of 0x8000–0x9FFF go to the video port with vid_addr_o = addr[12:0] (src_o = 2). Reads of 0xA000–0xBFFF go to the cartridge port with the full address.
- R11: A read of an unmapped address (for example 0xFF00) returns 0xFF with src_o = 0, and neither cart_req_o nor vid_req_o is raised.
- R12: Writes to 0x0000–0x7FFF and 0xA000–0xBFFF are passed to the cartridge port with cart_we_o high, even inside the overlay range, and they do not change the boot bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Bus address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| src_o | output | 3 | Read source: 0 none, 1 cartridge, 2 video, 3 boot, 4 work RAM |
| cart_req_o | output | 1 | Cartridge port request |
| cart_we_o | output | 1 | Cartridge port write |
| cart_addr_o | output | 16 | Cartridge port address |
| cart_wdata_o | output | 8 | Cartridge port write data |
| cart_rdata_i | input | 8 | Cartridge port read data |
| vid_req_o | output | 1 | Video port request |
| vid_we_o | output | 1 | Video port write |
| vid_addr_o | output | 13 | Video port address (offset in 0x8000–0x9FFF) |
| vid_wdata_o | output | 8 | Video port write data |
| vid_rdata_i | input | 8 | Video port read data |

## Verification
The bench drives one shared bus into three builds of the block: enhanced mode with a boot image, basic mode with a boot image, and basic mode without a boot image. Comparing the three side by side covers the wide and the narrow overlay, the header hole in both, and the cold-start case where the overlay is off from reset. All three use the default WRAM_AW=8. This keeps the banked RAM small while still letting the bench tell bank 0, bank 1 and bank 3 apart by the values they return. A second reset near the end shows that the overlay comes back and that the bank register returns to 1 while the RAM contents survive.

// File: rtl/boot_dec_pkg.sv
package boot_dec_pkg;

  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_CART  = 3'd1,
    SRC_VIDEO = 3'd2,
    SRC_BOOT  = 3'd3,
    SRC_WRAM  = 3'd4
  } src_e;

  localparam logic [15:0] OVL_OFF_ADDR  = 16'hFF50;
  localparam logic [15:0] BANK_SEL_ADDR = 16'hFF70;

  // Boot image is a fixed function of the byte offset.
  function automatic logic [7:0] boot_byte(input logic [11:0] a, input logic [7:0] seed);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ seed;
  endfunction

endpackage

// File: rtl/bod_addr_map.sv
module bod_addr_map
  import boot_dec_pkg::*;
#(
  parameter bit ENHANCED = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [15:0] addr_i,
  input  logic        boot_en_i,
  output src_e        tgt_o,
  output logic        ovl_wr_o,
  output logic        bank_wr_o
);

  logic in_low, in_ext, boot_hit;

  assign in_low = (addr_i[15:8] == 8'h00);

  generate
    if (ENHANCED) begin : g_wide
      assign in_ext = (addr_i >= 16'h0200) && (addr_i <= 16'h08FF);
    end else begin : g_narrow
      assign in_ext = 1'b0;
    end
  endgenerate

  assign boot_hit = req_i && !we_i && boot_en_i && (in_low || in_ext);

  always_comb begin
    tgt_o = SRC_NONE;
    if (req_i) begin
      if (boot_hit)                        tgt_o = SRC_BOOT;
      else if (!addr_i[15])                tgt_o = SRC_CART;
      else if (addr_i[15:13] == 3'b100)    tgt_o = SRC_VIDEO;
      else if (addr_i[15:13] == 3'b101)    tgt_o = SRC_CART;
      else if (addr_i[15:13] == 3'b110)    tgt_o = SRC_WRAM;
    end
  end

  assign ovl_wr_o  = req_i && we_i && (addr_i == OVL_OFF_ADDR);
  assign bank_wr_o = req_i && we_i && (addr_i == BANK_SEL_ADDR);

  // header hole is never covered by the overlay
  assert_hdr_hole_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[15:8] == 8'h01) |-> (tgt_o == SRC_CART));

  // boot bytes only on reads
  assert_boot_rd_only_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |-> (tgt_o != SRC_BOOT));

endmodule

// File: rtl/bod_ctrl.sv
module bod_ctrl #(
  parameter bit BOOT_PRESENT = 1'b1,
  parameter int BANK_W       = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ovl_wr_i,
  input  logic              bank_wr_i,
  input  logic [BANK_W-1:0] bank_val_i,
  output logic              boot_en_o,
  output logic [BANK_W-1:0] bank_o
);

  localparam logic [BANK_W-1:0] BANK_ONE = BANK_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       boot_en_o <= BOOT_PRESENT;
    else if (ovl_wr_i) boot_en_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        bank_o <= BANK_ONE;
    else if (bank_wr_i) bank_o <= (bank_val_i == '0) ? BANK_ONE : bank_val_i;
  end

  assert_ovl_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boot_en_o |=> !boot_en_o);

  assert_ovl_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovl_wr_i |=> !boot_en_o);

  assert_bank_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_wr_i && bank_val_i == '0) |=> (bank_o == BANK_ONE));

  assert_bank_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_wr_i |=> $stable(bank_o));

endmodule

// File: rtl/bod_wram.sv
module bod_wram #(
  parameter int BANKS  = 8,
  parameter int AW     = 8,
  parameter int BANK_W = 3
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              upper_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [AW-1:0]     off_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);

  localparam int DEPTH = BANKS << AW;
  localparam int IW    = BANK_W + AW;

  logic [7:0]        mem [DEPTH];
  logic [BANK_W-1:0] bsel;
  logic [IW-1:0]     idx;

  // lower window pinned to bank 0
  assign bsel    = upper_i ? bank_i : '0;
  assign idx     = {bsel, off_i};
  assign rdata_o = mem[idx];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[idx] <= wdata_i;
  end

endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
  import boot_dec_pkg::*;
#(
  parameter bit         ENHANCED     = 1'b0,
  parameter bit         BOOT_PRESENT = 1'b1,
  parameter int         WRAM_BANKS   = 8,
  parameter int         WRAM_AW      = 8,
  parameter logic [7:0] BOOT_SEED    = 8'h5C
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [15:0] addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic [2:0]  src_o,
  output logic        cart_req_o,
  output logic        cart_we_o,
  output logic [15:0] cart_addr_o,
  output logic [7:0]  cart_wdata_o,
  input  logic [7:0]  cart_rdata_i,
  output logic        vid_req_o,
  output logic        vid_we_o,
  output logic [12:0] vid_addr_o,
  output logic [7:0]  vid_wdata_o,
  input  logic [7:0]  vid_rdata_i
);

  localparam int BANK_W = $clog2(WRAM_BANKS);

  src_e              tgt;
  logic              boot_en, ovl_wr, bank_wr;
  logic [BANK_W-1:0] bank;
  logic [7:0]        wram_rdata;

  bod_addr_map #(.ENHANCED(ENHANCED)) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .boot_en_i (boot_en),
    .tgt_o     (tgt),
    .ovl_wr_o  (ovl_wr),
    .bank_wr_o (bank_wr)
  );

  bod_ctrl #(.BOOT_PRESENT(BOOT_PRESENT), .BANK_W(BANK_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ovl_wr_i   (ovl_wr),
    .bank_wr_i  (bank_wr),
    .bank_val_i (wdata_i[BANK_W-1:0]),
    .boot_en_o  (boot_en),
    .bank_o     (bank)
  );

  bod_wram #(.BANKS(WRAM_BANKS), .AW(WRAM_AW), .BANK_W(BANK_W)) u_wram (
    .clk_i   (clk_i),
    .we_i    ((tgt == SRC_WRAM) && we_i),
    .upper_i (addr_i[12]),
    .bank_i  (bank),
    .off_i   (addr_i[WRAM_AW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (wram_rdata)
  );

  assign cart_req_o   = (tgt == SRC_CART);
  assign cart_we_o    = cart_req_o && we_i;
  assign cart_addr_o  = addr_i;
  assign cart_wdata_o = wdata_i;

  assign vid_req_o    = (tgt == SRC_VIDEO);
  assign vid_we_o     = vid_req_o && we_i;
  assign vid_addr_o   = addr_i[12:0];
  assign vid_wdata_o  = wdata_i;

  assign src_o = tgt;

  always_comb begin
    unique case (tgt)
      SRC_CART:  rdata_o = cart_rdata_i;
      SRC_VIDEO: rdata_o = vid_rdata_i;
      SRC_BOOT:  rdata_o = boot_byte(addr_i[11:0], BOOT_SEED);
      SRC_WRAM:  rdata_o = wram_rdata;
      default:   rdata_o = 8'hFF;
    endcase
  end

  assert_port_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cart_req_o, vid_req_o}));

  assert_rom_wr_fwd_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !addr_i[15]) |-> (cart_req_o && cart_we_o));

  assert_vid_window_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[15:13] == 3'b100) |-> (vid_req_o && !cart_req_o));

endmodule

// File: tb/test_boot_overlay_decoder.sv
`timescale 1ns/100ps
module test_boot_overlay_decoder;

  localparam logic [7:0] SEED = 8'h5C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;

  int n_chk = 0, n_err = 0, cycles = 0;

  always #2.5 clk = ~clk;

  // Enhanced + image
  logic [7:0] rd_e, crd_e, vrd_e, cwd_e, vwd_e;
  logic [2:0] src_e;
  logic cr_e, cw_e, vr_e, vw_e;
  logic [15:0] ca_e;
  logic [12:0] va_e;
  // Basic + image
  logic [7:0] rd_b, crd_b, vrd_b, cwd_b, vwd_b;
  logic [2:0] src_b;
  logic cr_b, cw_b, vr_b, vw_b;
  logic [15:0] ca_b;
  logic [12:0] va_b;
  // Basic, no image
  logic [7:0] rd_c, crd_c, vrd_c, cwd_c, vwd_c;
  logic [2:0] src_c;
  logic cr_c, cw_c, vr_c, vw_c;
  logic [15:0] ca_c;
  logic [12:0] va_c;

  function automatic logic [7:0] cart_m(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  function automatic logic [7:0] vid_m(input logic [12:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction
  function automatic logic [7:0] boot_m(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ SEED;
  endfunction

  assign crd_e = cart_m(ca_e);  assign vrd_e = vid_m(va_e);
  assign crd_b = cart_m(ca_b);  assign vrd_b = vid_m(va_b);
  assign crd_c = cart_m(ca_c);  assign vrd_c = vid_m(va_c);

  boot_overlay_decoder #(.ENHANCED(1'b1), .BOOT_PRESENT(1'b1), .BOOT_SEED(SEED)) i_boot_overlay_decoder (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rd_e), .src_o(src_e), .cart_req_o(cr_e), .cart_we_o(cw_e), .cart_addr_o(ca_e),
    .cart_wdata_o(cwd_e), .cart_rdata_i(crd_e), .vid_req_o(vr_e), .vid_we_o(vw_e),
    .vid_addr_o(va_e), .vid_wdata_o(vwd_e), .vid_rdata_i(vrd_e));

  boot_overlay_decoder #(.ENHANCED(1'b0), .BOOT_PRESENT(1'b1), .BOOT_SEED(SEED)) i_boot_overlay_decoder_basic (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rd_b), .src_o(src_b), .cart_req_o(cr_b), .cart_we_o(cw_b), .cart_addr_o(ca_b),
    .cart_wdata_o(cwd_b), .cart_rdata_i(crd_b), .vid_req_o(vr_b), .vid_we_o(vw_b),
    .vid_addr_o(va_b), .vid_wdata_o(vwd_b), .vid_rdata_i(vrd_b));

  boot_overlay_decoder #(.ENHANCED(1'b0), .BOOT_PRESENT(1'b0), .BOOT_SEED(SEED)) i_boot_overlay_decoder_cold (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rd_c), .src_o(src_c), .cart_req_o(cr_c), .cart_we_o(cw_c), .cart_addr_o(ca_c),
    .cart_wdata_o(cwd_c), .cart_rdata_i(crd_c), .vid_req_o(vr_c), .vid_we_o(vw_c),
    .vid_addr_o(va_c), .vid_wdata_o(vwd_c), .vid_rdata_i(vrd_c));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic t_reset_state();
    rd(16'h0000);
    chk("R1 enh src", 16'(src_e), 16'd3);
    chk("R1 basic src", 16'(src_b), 16'd3);
    chk("R1 cold src", 16'(src_c), 16'd1);
    chk("R2 enh data", 16'(rd_e), 16'(boot_m(16'h0000)));
    chk("R1 cold data", 16'(rd_c), 16'(cart_m(16'h0000)));
    rd(16'h00FF);
    chk("R2 basic data 0xFF", 16'(rd_b), 16'(boot_m(16'h00FF)));
    chk("R2 basic src 0xFF", 16'(src_b), 16'd3);
  endtask

  task automatic t_overlay_span();
    rd(16'h0150);
    chk("R3 enh hole src", 16'(src_e), 16'd1);
    chk("R3 basic hole data", 16'(rd_b), 16'(cart_m(16'h0150)));
    rd(16'h0200);
    chk("R4 enh 0x200 src", 16'(src_e), 16'd3);
    chk("R4 enh 0x200 data", 16'(rd_e), 16'(boot_m(16'h0200)));
    chk("R4 basic 0x200 src", 16'(src_b), 16'd1);
    rd(16'h08FF);
    chk("R4 enh 0x8FF data", 16'(rd_e), 16'(boot_m(16'h08FF)));
    chk("R4 basic 0x8FF data", 16'(rd_b), 16'(cart_m(16'h08FF)));
    rd(16'h0900);
    chk("R4 enh 0x900 src", 16'(src_e), 16'd1);
  endtask

  task automatic t_ports();
    rd(16'h8123);
    chk("R10 vid src", 16'(src_e), 16'd2);
    chk("R10 vid addr", 16'(va_e), 16'h0123);
    chk("R10 vid data", 16'(rd_e), 16'(vid_m(13'h0123)));
    rd(16'h9FFF);
    chk("R10 vid top addr", 16'(va_b), 16'h1FFF);
    rd(16'hA010);
    chk("R10 xram src", 16'(src_e), 16'd1);
    chk("R10 xram data", 16'(rd_e), 16'(cart_m(16'hA010)));
    rd(16'hFF00);
    chk("R11 unmapped data", 16'(rd_e), 16'h00FF);
    chk("R11 unmapped src", 16'(src_e), 16'd0);
    chk("R11 no req", 16'({cr_e, vr_e}), 16'd0);
    // overlay-range write goes to cartridge
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 16'h0010; wdata = 8'h99;
    #1;
    chk("R12 wr cart req", 16'({cr_e, cw_e}), 16'b11);
    chk("R12 wr cart data", 16'(cwd_e), 16'h0099);
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0;
    rd(16'h0010);
    chk("R12 boot unchanged", 16'(rd_e), 16'(boot_m(16'h0010)));
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 16'h8004; wdata = 8'h42;
    #1;
    chk("R12 vid wr fwd", 16'({vr_e, vw_e, 3'b000, va_e}), 16'({2'b11, 3'b000, 13'h0004}));
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic t_wram();
    wr(16'hC020, 8'h00);
    wr(16'hD020, 8'h77);          // bank after reset
    wr(16'hFF70, 8'h01);
    rd(16'hD020);
    chk("R1 bank reset is 1", 16'(rd_e), 16'h0077);
    rd(16'hC020);
    chk("R7 bank0 separate", 16'(rd_e), 16'h0000);
    chk("R7 wram src", 16'(src_e), 16'd4);
    wr(16'hC010, 8'hAA);
    wr(16'hFF70, 8'h03);
    wr(16'hD010, 8'h33);
    wr(16'hFF70, 8'h00);
    wr(16'hD010, 8'h11);
    rd(16'hD010);
    chk("R9 zero selects 1", 16'(rd_e), 16'h0011);
    wr(16'hFF70, 8'hFB);          // bits [2:0] = 3
    rd(16'hD010);
    chk("R9 low bits only", 16'(rd_b), 16'h0033);
    rd(16'hC010);
    chk("R7 bank0 fixed", 16'(rd_e), 16'h00AA);
    wr(16'hFF70, 8'h01);
    rd(16'hD010);
    chk("R8 bank1 again", 16'(rd_c), 16'h0011);
  endtask

  task automatic t_retire();
    wr(16'hFF51, 8'hFF);
    wr(16'hFF5F, 8'h01);
    rd(16'h0000);
    chk("R5 ff51 ignored", 16'(src_e), 16'd3);
    wr(16'hFF50, 8'h00);
    rd(16'h0000);
    chk("R6 enh off src", 16'(src_e), 16'd1);
    chk("R6 basic off data", 16'(rd_b), 16'(cart_m(16'h0000)));
    rd(16'h0200);
    chk("R6 enh 0x200 cart", 16'(rd_e), 16'(cart_m(16'h0200)));
    rd(16'h08FF);
    chk("R6 enh 0x8FF src", 16'(src_e), 16'd1);
    wr(16'hFF50, 8'h01);
    wr(16'hFF51, 8'h01);
    rd(16'h0000);
    chk("R5 stays off", 16'(src_e), 16'd1);
    wr(16'hFF70, 8'h03);
    do_reset();
    rd(16'h0000);
    chk("R1 overlay back", 16'(src_e), 16'd3);
    chk("R1 cold still off", 16'(src_c), 16'd1);
    rd(16'hD010);
    chk("R1 bank back to 1", 16'(rd_e), 16'h0011);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      report();
    end
  end

  initial begin
    do_reset();
    t_reset_state();
    t_overlay_span();
    t_ports();
    t_wram();
    t_retire();
    report();
  end

endmodule